// File: doc/BRIEF.md
# Buffered PWM Timer Channel

This block is one up-counting timer channel that drives a single pulse-width-modulated pin from two compare registers. Compare register A sets the pin and compare register B clears it. Each compare register has a shadow buffer. Software writes the buffers at any time, and the hardware moves each buffered value into its active compare register at a chosen moment. That moment is either the compare register's own match, or any event that returns the counter to zero.

Software sets up the channel through a simple write port while the counter is stopped. It then starts counting with the run input. An external clock enable paces the count. To change the waveform without glitches, software writes new values into the buffers. It can choose copy-on-clear so that both edges change together at a period boundary.

Top module: `pwm_buf_timer`

## Requirements
- R1: After reset the pin is 0, the counter and all compare and buffer registers are 0, the clear source is "none" and the transfer mode is 0.
- R2: The counter advances by one in each cycle in which run and cnt_en are both 1 (a tick). In all other cycles it holds. From 0xFFFF it wraps to 0x0000.
- R3: A match of register X occurs in a tick cycle in which the counter equals compare X. One cycle later the pin is 1 after a match of A and 0 after a match of B. When both match in the same cycle, B wins and the pin goes to 0.
- R4: The clear source field is control bits [1:0]: 00 means no clear, 01 means clear on a match of A, 10 means clear on a match of B, and 11 behaves as no clear. A hardware clear loads 0 at the matching tick, so the counter reads 0 after that tick instead of the matched value plus one.
- R5: With transfer mode (control bit 2) at 0, each buffer is copied into its own compare register in the cycle of that register's match.
- R6: With transfer mode at 1, both buffers are copied on any clear event. A clear event is an overflow from 0xFFFF, a bus write of 0 to the counter while run is 1, or a hardware clear. A write of 0 to the counter while stopped is not a clear event.
- R7: When a copy and a bus write to the same buffer fall in one cycle, the compare register takes the old buffer value, and the buffer keeps the newly written value for the next copy event.
- R8: A control write while run is 1 updates the clear source but leaves the transfer mode unchanged.
- R9: While run is 0 the counter, the pin and the compare registers hold. Only direct bus writes change a register.
- R10: The write addresses are: 0 counter, 1 compare A, 2 compare B, 3 buffer A, 4 buffer B, 5 control. A counter write takes priority over counting and clearing. A direct compare write takes priority over a copy in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start (1) / stop (0) the counter |
| cnt_en | input | 1 | Count clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | PWM pin |

## Verification
The collision of interest is a buffer transfer landing in the same cycle as a bus write to that buffer. This can happen with a compare match in mode 0 or with any clear event in mode 1. It is provoked by writing a buffer with a changing value on every cycle of a running window, so that some writes must coincide with transfers. A second collision puts the same value in both compare registers, so the set and clear edges coincide. A cycle-level model built from the requirements predicts the pin for every cycle, and a scoreboard compares it against the pin. The wrong transfer choice shifts later edges and so shows up at the pin.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CNT  = 3'd0,
    ADDR_CMPA = 3'd1,
    ADDR_CMPB = 3'd2,
    ADDR_BUFA = 3'd3,
    ADDR_BUFB = 3'd4,
    ADDR_CTRL = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_RSVD = 2'b11
  } clr_src_e;

  localparam int CTRL_MODE_BIT = 2;
endpackage

// File: rtl/pbt_counter.sv
module pbt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  input  logic         hw_clr,
  output logic [W-1:0] cnt_q,
  output logic         ovf
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)      cnt_d = wr_data;
    else if (tick)   cnt_d = hw_clr ? '0 : W'(cnt_q + 1'b1);
  end

  assign ovf = tick && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: counting, holding and wrap
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && !hw_clr && cnt_q != {W{1'b1}}) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_cnt && !hw_clr) |=> cnt_q == '0);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt_q));
  // R4: hardware clear lands on zero
  p_hwclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_clr && !wr_cnt) |=> cnt_q == '0);
endmodule

// File: rtl/pbt_slot.sv
module pbt_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         wr_cmp,
  input  logic         wr_buf,
  input  logic [W-1:0] wr_data,
  input  logic         copy_on_clr,
  input  logic         clr_evt,
  output logic         match,
  output logic [W-1:0] cmp_q
);
  logic [W-1:0] buf_q, buf_d, cmp_d;
  logic         copy;

  assign match = tick && (cnt == cmp_q);
  assign copy  = copy_on_clr ? clr_evt : match;

  always_comb begin
    buf_d = wr_buf ? wr_data : buf_q;
    cmp_d = cmp_q;
    if (wr_cmp)    cmp_d = wr_data;
    else if (copy) cmp_d = buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      buf_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      buf_q <= buf_d;
    end
  end

  // R5: copy on own match in mode 0
  p_match_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!copy_on_clr && match && !wr_cmp) |=> cmp_q == $past(buf_q));
  // R6: copy on clear event in mode 1
  p_clr_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_on_clr && clr_evt && !wr_cmp) |=> cmp_q == $past(buf_q));
  // R7: collision keeps the old buffer for the compare, new for the buffer
  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy && wr_buf && !wr_cmp) |=> (cmp_q == $past(buf_q)) && (buf_q == $past(wr_data)));
  // R9: no transfers while stopped
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cmp) |=> $stable(cmp_q));
endmodule

// File: rtl/pbt_wave.sv
module pbt_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic set_hi,
  input  logic set_lo,
  output logic pin_q
);
  logic pin_d;

  always_comb begin
    pin_d = pin_q;
    if (set_lo)      pin_d = 1'b0;
    else if (set_hi) pin_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end
endmodule

// File: rtl/pwm_buf_timer.sv
module pwm_buf_timer
  import pwm_buf_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              pwm_out
);
  localparam int NSLOT = 2;

  clr_src_e     src_q, src_d;
  logic         mode_q, mode_d;
  logic         tick, wr_cnt, wr_ctrl, hw_clr, soft_zero, ovf, clr_evt;
  logic [W-1:0] cnt_q;
  logic [NSLOT-1:0] match;
  logic [W-1:0] cmp_q [NSLOT];

  assign tick      = run && cnt_en;
  assign wr_cnt    = wr_en && (wr_addr == ADDR_CNT);
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign hw_clr    = ((src_q == CLR_ON_A) && match[0]) || ((src_q == CLR_ON_B) && match[1]);
  assign soft_zero = wr_cnt && run && (wr_data == '0);
  assign clr_evt   = hw_clr || ovf || soft_zero;

  always_comb begin
    src_d  = src_q;
    mode_d = mode_q;
    if (wr_ctrl) begin
      src_d = clr_src_e'(wr_data[1:0]);
      if (!run) mode_d = wr_data[CTRL_MODE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= CLR_NONE;
      mode_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      mode_q <= mode_d;
    end
  end

  pbt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_cnt(wr_cnt),
    .wr_data(wr_data), .hw_clr(hw_clr), .cnt_q(cnt_q), .ovf(ovf)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic wr_cmp_g, wr_buf_g;
    assign wr_cmp_g = wr_en && (wr_addr == ADDR_W'(int'(ADDR_CMPA) + g));
    assign wr_buf_g = wr_en && (wr_addr == ADDR_W'(int'(ADDR_BUFA) + g));
    pbt_slot #(.W(W)) u_slot (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cnt(cnt_q),
      .wr_cmp(wr_cmp_g), .wr_buf(wr_buf_g), .wr_data(wr_data),
      .copy_on_clr(mode_q), .clr_evt(clr_evt),
      .match(match[g]), .cmp_q(cmp_q[g])
    );
  end

  pbt_wave u_wave (
    .clk(clk), .rst_n(rst_n), .set_hi(match[0]), .set_lo(match[1]), .pin_q(pwm_out)
  );

  // R3: pin edges follow matches, B wins a tie
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match[0] && !match[1]) |=> pwm_out);
  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match[1] |=> !pwm_out);
  // R8: transfer mode locked while running
  p_mode_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_q));
  // R9: pin holds while stopped
  p_pin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pwm_out));
  // R1: reset leaves every output low before the first match
  p_reset_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_out && !match[0]) |=> !pwm_out);
endmodule

// File: tb/pwm_buf_timer_tb.sv
module pwm_buf_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, cen = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] data = '0;
  logic        pwm_out;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    exp_q[$];

  always #10 clk = ~clk;

  pwm_buf_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cnt_en(cen), .wr_en(we),
    .wr_addr(addr), .wr_data(data), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s pwm_out actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model written from the requirements; pushes expected pin per cycle.
  logic [15:0] m_cnt, m_ca, m_cb, m_ba, m_bb;
  logic [1:0]  m_src;
  logic        m_mode, m_pin;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ca = 0; m_cb = 0; m_ba = 0; m_bb = 0;
      m_src = 0; m_mode = 0; m_pin = 0;
    end else begin
      bit t, ma, mb, hw, clr, ca_go, cb_go;
      t  = run && cen;
      ma = t && (m_cnt == m_ca);
      mb = t && (m_cnt == m_cb);
      hw = (m_src == 2'b01 && ma) || (m_src == 2'b10 && mb);
      clr = hw || (t && m_cnt == 16'hFFFF) || (run && we && addr == 3'd0 && data == 16'h0);
      ca_go = m_mode ? clr : ma;
      cb_go = m_mode ? clr : mb;
      if (mb) m_pin = 1'b0; else if (ma) m_pin = 1'b1;
      if (we && addr == 3'd1) m_ca = data; else if (ca_go) m_ca = m_ba;
      if (we && addr == 3'd2) m_cb = data; else if (cb_go) m_cb = m_bb;
      if (we && addr == 3'd3) m_ba = data;
      if (we && addr == 3'd4) m_bb = data;
      if (we && addr == 3'd5) begin
        m_src = data[1:0];
        if (!run) m_mode = data[2];
      end
      if (we && addr == 3'd0) m_cnt = data;
      else if (t) m_cnt = hw ? 16'h0 : m_cnt + 16'd1;
      exp_q.push_back(m_pin);
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) check(cur_req, pwm_out, exp_q.pop_front());
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; data = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", pwm_out, 1'b0);               // R1: pin low after reset
    // R10: register map writes while stopped; clear on B, mode 0
    cur_req = "R10";
    wr(3'd5, 16'h0002); wr(3'd1, 16'd3); wr(3'd2, 16'd9);
    wr(3'd3, 16'd5);    wr(3'd4, 16'd9);
    // R5: copy on own match
    cur_req = "R5";
    run = 1'b1; cen = 1'b1; idle(40);
    // R2: gated count
    cur_req = "R2";
    for (int i = 0; i < 60; i++) begin cen = (i % 3 != 0); @(negedge clk); end
    cen = 1'b1;
    // R7: buffer written every cycle so writes hit copy cycles
    cur_req = "R7";
    for (int i = 0; i < 40; i++) begin
      we = 1'b1; addr = 3'd3; data = 16'(4 + (i % 5)); @(negedge clk);
    end
    we = 1'b0; idle(20);
    // R3: equal compares, B wins
    cur_req = "R3";
    wr(3'd4, 16'd6); wr(3'd3, 16'd6); idle(30);
    wr(3'd3, 16'd2); idle(30);
    // R9: stopped, writes to buffers and counter only
    cur_req = "R9";
    run = 1'b0; wr(3'd3, 16'd7); wr(3'd4, 16'd12); wr(3'd0, 16'd5); idle(10);
    run = 1'b1; idle(30);
    // R4: clear on A, then reserved code as free run
    cur_req = "R4";
    run = 1'b0; wr(3'd5, 16'h0001); wr(3'd1, 16'd4); wr(3'd2, 16'd8);
    wr(3'd3, 16'd4); wr(3'd4, 16'd8);
    run = 1'b1; idle(30);
    run = 1'b0; wr(3'd5, 16'h0003); wr(3'd0, 16'hFFF0); wr(3'd1, 16'd2); wr(3'd3, 16'd2);
    run = 1'b1; idle(40);
    // R6: mode 1, hardware clear, software zero, overflow
    cur_req = "R6";
    run = 1'b0; wr(3'd5, 16'h0006); wr(3'd1, 16'd10); wr(3'd2, 16'd20);
    wr(3'd3, 16'd15); wr(3'd4, 16'd25); wr(3'd0, 16'd0);
    run = 1'b1; idle(80);
    wr(3'd3, 16'd3); wr(3'd4, 16'd7); wr(3'd0, 16'd0); idle(30);
    run = 1'b0; wr(3'd5, 16'h0004); wr(3'd3, 16'd1); wr(3'd4, 16'd5);
    wr(3'd0, 16'h0000);                       // stopped zero write: no clear
    wr(3'd0, 16'hFFD0); run = 1'b1; idle(100);
    // R8: mode write while running is ignored
    cur_req = "R8";
    wr(3'd5, 16'h0002); wr(3'd3, 16'd30); wr(3'd4, 16'd40); idle(60);
    run = 1'b0; wr(3'd5, 16'h0002); run = 1'b1; idle(60);
    // R10: counter write overrides count, compare write overrides copy
    cur_req = "R10";
    wr(3'd0, 16'd100); idle(10);
    for (int i = 0; i < 30; i++) begin
      we = 1'b1; addr = 3'd1; data = 16'(3 + (i % 4)); @(negedge clk);
    end
    we = 1'b0; idle(40);
    run = 1'b0; idle(5);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule